// File: doc/BRIEF.md
# Variable-Length Instruction Word Decoder

This block sits in the front end of a 16-bit, word-addressed processor. It receives the first word of an instruction together with the two memory words that follow it. It splits the first word into an opcode and two operand fields. Operand b is the destination and operand a is the source. The block then classifies each operand into an addressing mode. It also decides which of the trailing words each operand consumes, and it reports how many words the whole instruction occupies.

A caller strobes `in_valid` with the three words. One clock later, the registered result appears with `out_valid` high. The result holds the mode of each operand, its register index, and its data word: either the trailing word it consumes or, for a short literal, the literal value itself. It also holds the instruction length and a flag that marks the instruction as a conditional. The sequencer uses the length to advance the program counter or to skip an instruction. When the instruction being skipped is itself a conditional, the sequencer uses the conditional flag to skip the next instruction too, at one extra cycle per link in the chain. The register file and memory ports are outside this block.

Top module: `instr_word_decoder`

## Requirements
- R1: The first word is split as opcode = bits 4:0, operand b = bits 9:5 and operand a = bits 15:10. `out_opcode` carries bits 4:0 of the strobed word.
- R2: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was high, and low otherwise. When `in_valid` is low, every decoded field keeps its previous value.
- R3: Operand codes 0x00-0x07 give mode 0 (register). Codes 0x08-0x0F give mode 1 (memory at register). Codes 0x10-0x17 give mode 2 (memory at register plus trailing word). In all three cases the register index is the low three bits of the code.
- R4: Code 0x18 gives mode 3 (push, pre-decrement of the stack pointer) when it is operand b, and mode 4 (pop, post-increment) when it is operand a.
- R5: Code 0x19 gives mode 5 (memory at the stack pointer). Code 0x1A gives mode 6 (memory at the stack pointer plus trailing word).
- R6: Codes 0x1B, 0x1C and 0x1D give modes 7, 8 and 9: stack pointer, program counter and overflow register. None of these consumes a trailing word.
- R7: Code 0x1E gives mode 10 (memory at trailing word). Code 0x1F gives mode 11 (trailing word as literal).
- R8: Operand a codes 0x20-0x3F give mode 12 (short literal). Their data word is (code & 0x1F) - 1 modulo 2^16, which runs from 0xFFFF up to 0x1E. They consume no trailing word.
- R9: Modes 2, 6, 10 and 11 consume a trailing word. Operand b takes the first trailing word. Operand a takes the next unused one. An operand that consumes no word and is not a short literal reports data 0.
- R10: `out_len` is 1 plus the number of trailing words consumed, in the range 1 to 3.
- R11: Opcode 0 marks a special instruction. `out_special` is 1 and `out_sub_op` carries the b field. Operand b is reported as mode 13 (none) with data 0, it consumes no word, and only operand a is decoded. For all other opcodes `out_sub_op` is 0.
- R12: `out_cond` is 1 exactly for opcodes 0x10-0x17.
- R13: During and after reset, before any strobe, `out_valid`, `out_len` and `out_cond` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: the three words are to be decoded |
| in_word0 | input | 16 | First instruction word |
| in_word1 | input | 16 | Memory word following the first |
| in_word2 | input | 16 | Memory word two after the first |
| out_valid | output | 1 | Decoded result valid this cycle |
| out_opcode | output | 5 | Opcode field |
| out_special | output | 1 | Opcode is 0 (special instruction) |
| out_sub_op | output | 5 | Sub-opcode of a special instruction |
| out_b_mode | output | 4 | Addressing mode of operand b |
| out_b_reg | output | 3 | Register index of operand b |
| out_b_data | output | 16 | Trailing word used by operand b, else 0 |
| out_a_mode | output | 4 | Addressing mode of operand a |
| out_a_reg | output | 3 | Register index of operand a |
| out_a_data | output | 16 | Trailing word or short literal of operand a, else 0 |
| out_len | output | 2 | Instruction length in words |
| out_cond | output | 1 | Instruction is a conditional |

## Verification
Every decoded field is due in the cycle after the strobe, because one register stage lies between the inputs and the outputs. The bench drives each strobe for exactly one cycle on a falling edge, so the decode is captured on the next rising edge. It reads the results on the falling edge that follows, halfway through the cycle in which `out_valid` is high. For the hold behaviour, it leaves the strobe low for several more cycles and confirms that `out_valid` has dropped while the fields still hold their old values.

// File: rtl/iwd_pkg.sv
package iwd_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_REG   = 4'd0,
    MODE_IND   = 4'd1,
    MODE_IDX   = 4'd2,
    MODE_PUSH  = 4'd3,
    MODE_POP   = 4'd4,
    MODE_PEEK  = 4'd5,
    MODE_PICK  = 4'd6,
    MODE_SP    = 4'd7,
    MODE_PC    = 4'd8,
    MODE_EX    = 4'd9,
    MODE_MEMNW = 4'd10,
    MODE_LITNW = 4'd11,
    MODE_LITIN = 4'd12,
    MODE_NONE  = 4'd13
  } mode_e;

  // Modes that read one trailing word from the instruction stream
  function automatic logic mode_takes_word(input logic [MODE_W-1:0] m);
    return (m == MODE_IDX) || (m == MODE_PICK) ||
           (m == MODE_MEMNW) || (m == MODE_LITNW);
  endfunction

endpackage

// File: rtl/iwd_operand_class.sv
module iwd_operand_class
  import iwd_pkg::*;
#(
  parameter int CODE_W  = 6,
  parameter int WORD_W  = 16,
  parameter int REG_W   = 3,
  parameter bit IS_DEST = 1'b0
)(
  input  logic [CODE_W-1:0] code,
  input  logic              enable,
  output mode_e             mode,
  output logic [REG_W-1:0]  reg_idx,
  output logic              needs_word,
  output logic [WORD_W-1:0] lit_val
);

  localparam int EXT_W = 6;

  logic [EXT_W-1:0] code_x;
  mode_e            stack_mode;

  assign code_x = EXT_W'(code);

  // The shared stack code means push for a destination and pop for a source
  generate
    if (IS_DEST) begin : g_dest
      assign stack_mode = MODE_PUSH;
    end else begin : g_src
      assign stack_mode = MODE_POP;
    end
  endgenerate

  always_comb begin
    mode       = MODE_NONE;
    needs_word = 1'b0;
    reg_idx    = code_x[REG_W-1:0];
    lit_val    = '0;
    if (enable) begin
      if (code_x[5]) begin
        mode    = MODE_LITIN;
        lit_val = WORD_W'(code_x[4:0]) - WORD_W'(1);
      end else begin
        unique case (code_x[4:3])
          2'b00: mode = MODE_REG;
          2'b01: mode = MODE_IND;
          2'b10: begin
            mode       = MODE_IDX;
            needs_word = 1'b1;
          end
          default: begin
            unique case (code_x[2:0])
              3'd0: mode = stack_mode;
              3'd1: mode = MODE_PEEK;
              3'd2: begin
                mode       = MODE_PICK;
                needs_word = 1'b1;
              end
              3'd3: mode = MODE_SP;
              3'd4: mode = MODE_PC;
              3'd5: mode = MODE_EX;
              3'd6: begin
                mode       = MODE_MEMNW;
                needs_word = 1'b1;
              end
              default: begin
                mode       = MODE_LITNW;
                needs_word = 1'b1;
              end
            endcase
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/iwd_word_select.sv
module iwd_word_select #(
  parameter int WORD_W = 16,
  parameter int LEN_W  = 2
)(
  input  logic              b_need,
  input  logic              a_need,
  input  logic [WORD_W-1:0] word1,
  input  logic [WORD_W-1:0] word2,
  output logic [WORD_W-1:0] b_word,
  output logic [WORD_W-1:0] a_word,
  output logic [LEN_W-1:0]  len
);

  always_comb begin
    b_word = b_need ? word1 : '0;
    if (!a_need)     a_word = '0;
    else if (b_need) a_word = word2;
    else             a_word = word1;
    len = LEN_W'(1) + LEN_W'(b_need) + LEN_W'(a_need);
  end

endmodule

// File: rtl/instr_word_decoder.sv
module instr_word_decoder
  import iwd_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int OPC_W  = 5,
  parameter int B_W    = 5,
  parameter int A_W    = 6,
  parameter int REG_W  = 3,
  parameter int LEN_W  = 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word0,
  input  logic [WORD_W-1:0] in_word1,
  input  logic [WORD_W-1:0] in_word2,
  output logic              out_valid,
  output logic [OPC_W-1:0]  out_opcode,
  output logic              out_special,
  output logic [B_W-1:0]    out_sub_op,
  output logic [3:0]        out_b_mode,
  output logic [REG_W-1:0]  out_b_reg,
  output logic [WORD_W-1:0] out_b_data,
  output logic [3:0]        out_a_mode,
  output logic [REG_W-1:0]  out_a_reg,
  output logic [WORD_W-1:0] out_a_data,
  output logic [LEN_W-1:0]  out_len,
  output logic              out_cond
);

  localparam int B_LSB    = OPC_W;
  localparam int A_LSB    = OPC_W + B_W;
  localparam int RST_SYNC = 2;

  // Reset synchronizer: asserts asynchronously, releases on the clock
  logic [RST_SYNC-1:0] rst_pipe;
  logic                rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_SYNC-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[RST_SYNC-1];

  // Field split
  logic [OPC_W-1:0] opc_f;
  logic [B_W-1:0]   b_f;
  logic [A_W-1:0]   a_f;
  logic             spec_nxt;

  assign opc_f    = in_word0[OPC_W-1:0];
  assign b_f      = in_word0[B_LSB +: B_W];
  assign a_f      = in_word0[A_LSB +: A_W];
  assign spec_nxt = (opc_f == '0);

  // Operand classification, one instance per role
  mode_e             b_mode_c, a_mode_c;
  logic [REG_W-1:0]  b_reg_c, a_reg_c;
  logic              b_need_c, a_need_c;
  logic [WORD_W-1:0] b_lit_c, a_lit_c;

  iwd_operand_class #(
    .CODE_W(B_W), .WORD_W(WORD_W), .REG_W(REG_W), .IS_DEST(1'b1)
  ) u_class_b (
    .code(b_f), .enable(!spec_nxt), .mode(b_mode_c), .reg_idx(b_reg_c),
    .needs_word(b_need_c), .lit_val(b_lit_c)
  );

  iwd_operand_class #(
    .CODE_W(A_W), .WORD_W(WORD_W), .REG_W(REG_W), .IS_DEST(1'b0)
  ) u_class_a (
    .code(a_f), .enable(1'b1), .mode(a_mode_c), .reg_idx(a_reg_c),
    .needs_word(a_need_c), .lit_val(a_lit_c)
  );

  // Trailing-word steering and length
  logic [WORD_W-1:0] b_word_c, a_word_c;
  logic [LEN_W-1:0]  len_c;

  iwd_word_select #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_words (
    .b_need(b_need_c), .a_need(a_need_c), .word1(in_word1), .word2(in_word2),
    .b_word(b_word_c), .a_word(a_word_c), .len(len_c)
  );

  // Next-state values
  logic [B_W-1:0]    sub_nxt;
  logic [WORD_W-1:0] a_data_nxt;
  logic [REG_W-1:0]  b_reg_nxt;
  logic              cond_nxt;

  always_comb begin
    sub_nxt    = spec_nxt ? b_f : '0;
    b_reg_nxt  = spec_nxt ? '0 : b_reg_c;
    a_data_nxt = (a_mode_c == MODE_LITIN) ? a_lit_c : a_word_c;
    cond_nxt   = !spec_nxt && (opc_f[OPC_W-1 -: 2] == 2'b10);
  end

  // Result registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) out_valid <= 1'b0;
    else             out_valid <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_opcode  <= '0;
      out_special <= 1'b0;
      out_sub_op  <= '0;
      out_b_mode  <= '0;
      out_b_reg   <= '0;
      out_b_data  <= '0;
      out_a_mode  <= '0;
      out_a_reg   <= '0;
      out_a_data  <= '0;
      out_len     <= '0;
      out_cond    <= 1'b0;
    end else if (in_valid) begin
      out_opcode  <= opc_f;
      out_special <= spec_nxt;
      out_sub_op  <= sub_nxt;
      out_b_mode  <= b_mode_c;
      out_b_reg   <= b_reg_nxt;
      out_b_data  <= b_word_c;
      out_a_mode  <= a_mode_c;
      out_a_reg   <= a_reg_c;
      out_a_data  <= a_data_nxt;
      out_len     <= len_c;
      out_cond    <= cond_nxt;
    end
  end

endmodule

// File: rtl/iwd_checker.sv
module iwd_checker
  import iwd_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int OPC_W  = 5,
  parameter int LEN_W  = 2
)(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [WORD_W-1:0] in_word0,
  input logic              out_valid,
  input logic [OPC_W-1:0]  out_opcode,
  input logic              out_special,
  input logic [3:0]        out_b_mode,
  input logic [3:0]        out_a_mode,
  input logic [LEN_W-1:0]  out_len,
  input logic              out_cond
);

  logic [LEN_W-1:0] exp_len;
  assign exp_len = LEN_W'(1) + LEN_W'(mode_takes_word(out_b_mode))
                 + LEN_W'(mode_takes_word(out_a_mode));

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_opcode) && $stable(out_len) && $stable(out_a_mode)); // R2
  AST_OPCODE_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_opcode == $past(in_word0[OPC_W-1:0])); // R1
  AST_LEN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_len == exp_len); // R10
  AST_SPECIAL_NO_B: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_special |-> out_b_mode == MODE_NONE && !out_cond); // R11
  AST_COND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_cond == ($past(in_word0[OPC_W-1:0]) >= OPC_W'(16) &&
                              $past(in_word0[OPC_W-1:0]) <= OPC_W'(23))); // R12
  AST_STACK_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_b_mode != MODE_POP && out_a_mode != MODE_PUSH); // R4

endmodule

bind instr_word_decoder iwd_checker #(
  .WORD_W(WORD_W), .OPC_W(OPC_W), .LEN_W(LEN_W)
) u_iwd_checker (
  .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .in_word0(in_word0),
  .out_valid(out_valid), .out_opcode(out_opcode), .out_special(out_special),
  .out_b_mode(out_b_mode), .out_a_mode(out_a_mode), .out_len(out_len),
  .out_cond(out_cond)
);

// File: tb/instr_word_decoder_tb_top.sv
`timescale 1ns/1ps
module instr_word_decoder_tb_top;

  localparam int M_REG = 0, M_IND = 1, M_IDX = 2, M_PUSH = 3, M_POP = 4,
                 M_PEEK = 5, M_PICK = 6, M_SP = 7, M_PC = 8, M_EX = 9,
                 M_MEMNW = 10, M_LITNW = 11, M_LITIN = 12, M_NONE = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_word0 = '0, in_word1 = '0, in_word2 = '0;
  logic        out_valid, out_special, out_cond;
  logic [4:0]  out_opcode, out_sub_op;
  logic [3:0]  out_b_mode, out_a_mode;
  logic [2:0]  out_b_reg, out_a_reg;
  logic [15:0] out_b_data, out_a_data;
  logic [1:0]  out_len;

  int n_checks = 0;
  int n_errors = 0;

  always #5 clk = ~clk;

  instr_word_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_word0(in_word0), .in_word1(in_word1), .in_word2(in_word2),
    .out_valid(out_valid), .out_opcode(out_opcode), .out_special(out_special),
    .out_sub_op(out_sub_op), .out_b_mode(out_b_mode), .out_b_reg(out_b_reg),
    .out_b_data(out_b_data), .out_a_mode(out_a_mode), .out_a_reg(out_a_reg),
    .out_a_data(out_a_data), .out_len(out_len), .out_cond(out_cond)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input int op, input int b, input int a);
    logic [5:0] a6 = a[5:0];
    logic [4:0] b5 = b[4:0];
    logic [4:0] o5 = op[4:0];
    return {a6, b5, o5};
  endfunction

  // One-cycle strobe; results are read on the following falling edge
  task automatic strobe(input logic [15:0] w0, input logic [15:0] w1,
                        input logic [15:0] w2);
    @(negedge clk);
    in_word0 = w0; in_word1 = w1; in_word2 = w2; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R13", "valid", 32'(out_valid), 0);
    chk("R13", "len", 32'(out_len), 0);
    chk("R13", "cond", 32'(out_cond), 0);
  endtask

  task automatic t_registers();
    strobe(mk(1, 3, 5), 16'h1111, 16'h2222);
    chk("R2", "valid", 32'(out_valid), 1);
    chk("R1", "opcode", 32'(out_opcode), 1);
    chk("R3", "b mode", 32'(out_b_mode), M_REG);
    chk("R3", "b reg", 32'(out_b_reg), 3);
    chk("R3", "a reg", 32'(out_a_reg), 5);
    chk("R9", "b data", 32'(out_b_data), 0);
    chk("R10", "len", 32'(out_len), 1);
    chk("R11", "special", 32'(out_special), 0);
    chk("R11", "sub op", 32'(out_sub_op), 0);
  endtask

  task automatic t_indirect();
    strobe(mk(2, 8'h0A, 8'h12), 16'h1234, 16'h5555);
    chk("R3", "b mode", 32'(out_b_mode), M_IND);
    chk("R3", "b reg", 32'(out_b_reg), 2);
    chk("R3", "a mode", 32'(out_a_mode), M_IDX);
    chk("R3", "a reg", 32'(out_a_reg), 2);
    chk("R9", "a data", 32'(out_a_data), 16'h1234);
    chk("R10", "len", 32'(out_len), 2);
  endtask

  task automatic t_two_words();
    strobe(mk(3, 8'h10, 8'h1F), 16'hAAAA, 16'hBBBB);
    chk("R9", "b data", 32'(out_b_data), 16'hAAAA);
    chk("R9", "a data", 32'(out_a_data), 16'hBBBB);
    chk("R7", "a mode", 32'(out_a_mode), M_LITNW);
    chk("R10", "len", 32'(out_len), 3);
  endtask

  task automatic t_stack();
    strobe(mk(1, 8'h18, 8'h18), 16'h0, 16'h0);
    chk("R4", "b mode", 32'(out_b_mode), M_PUSH);
    chk("R4", "a mode", 32'(out_a_mode), M_POP);
    chk("R10", "len", 32'(out_len), 1);
    strobe(mk(1, 8'h1A, 8'h19), 16'h0007, 16'h0009);
    chk("R5", "b mode", 32'(out_b_mode), M_PICK);
    chk("R5", "b data", 32'(out_b_data), 7);
    chk("R5", "a mode", 32'(out_a_mode), M_PEEK);
    chk("R9", "a data", 32'(out_a_data), 0);
    chk("R10", "len", 32'(out_len), 2);
  endtask

  task automatic t_special_regs();
    strobe(mk(1, 8'h1B, 8'h1C), 16'h7777, 16'h8888);
    chk("R6", "b mode", 32'(out_b_mode), M_SP);
    chk("R6", "a mode", 32'(out_a_mode), M_PC);
    chk("R6", "len", 32'(out_len), 1);
    strobe(mk(1, 8'h1D, 8'h1E), 16'h4000, 16'h5000);
    chk("R6", "b mode", 32'(out_b_mode), M_EX);
    chk("R7", "a mode", 32'(out_a_mode), M_MEMNW);
    chk("R7", "a data", 32'(out_a_data), 16'h4000);
    chk("R10", "len", 32'(out_len), 2);
  endtask

  task automatic t_literals();
    strobe(mk(1, 0, 8'h20), 16'h1234, 16'h1234);
    chk("R8", "a mode", 32'(out_a_mode), M_LITIN);
    chk("R8", "lit 0x20", 32'(out_a_data), 16'hFFFF);
    chk("R8", "len", 32'(out_len), 1);
    strobe(mk(1, 0, 8'h21), 16'h1234, 16'h1234);
    chk("R8", "lit 0x21", 32'(out_a_data), 0);
    strobe(mk(1, 0, 8'h3F), 16'h1234, 16'h1234);
    chk("R8", "lit 0x3F", 32'(out_a_data), 16'h001E);
  endtask

  task automatic t_special_op();
    strobe(mk(0, 8'h10, 8'h1F), 16'h9999, 16'h6666);
    chk("R11", "special", 32'(out_special), 1);
    chk("R11", "sub op", 32'(out_sub_op), 16);
    chk("R11", "b mode", 32'(out_b_mode), M_NONE);
    chk("R11", "b data", 32'(out_b_data), 0);
    chk("R11", "a data", 32'(out_a_data), 16'h9999);
    chk("R11", "len", 32'(out_len), 2);
    chk("R11", "cond", 32'(out_cond), 0);
  endtask

  task automatic t_cond();
    strobe(mk(16, 0, 0), 0, 0);
    chk("R12", "op 0x10", 32'(out_cond), 1);
    strobe(mk(23, 0, 0), 0, 0);
    chk("R12", "op 0x17", 32'(out_cond), 1);
    strobe(mk(15, 0, 0), 0, 0);
    chk("R12", "op 0x0F", 32'(out_cond), 0);
    strobe(mk(24, 0, 0), 0, 0);
    chk("R12", "op 0x18", 32'(out_cond), 0);
  endtask

  task automatic t_hold();
    strobe(mk(19, 8'h1A, 8'h1E), 16'h0100, 16'h0200);
    @(negedge clk);
    in_word0 = mk(2, 1, 1);
    in_word1 = 16'hDEAD;
    repeat (3) @(negedge clk);
    chk("R2", "valid low", 32'(out_valid), 0);
    chk("R2", "opcode held", 32'(out_opcode), 19);
    chk("R2", "len held", 32'(out_len), 3);
    chk("R2", "a data held", 32'(out_a_data), 16'h0200);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_registers();
    t_indirect();
    t_two_words();
    t_stack();
    t_special_regs();
    t_literals();
    t_special_op();
    t_cond();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule